// File: doc/BRIEF.md
# Shifting XOR Tile Blitter

This block draws a bitmap held in a small on-chip tile cache onto a frame buffer that is itself stored as a grid of 8x8-pixel tiles. Each tile is eight bytes, one per pixel row, with the most significant bit as the leftmost pixel. A command places the bitmap at the current pen position, in tile units, and can shift it right and down by up to seven pixels. Pixels that a shift pushes out of one tile column or row spill into one more column or row. The frame buffer is read, combined and written back one byte at a time. Sprite blits combine with XOR, so drawing the same sprite twice restores the screen. Background blits overwrite and can repeat the bitmap across and down.

The block also holds a pen position and a clip extent. After each blit the pen moves right by the number of tile columns just drawn, as a text cursor does. Bytes outside the clip rectangle anchored at the pen, and bytes beyond the edge of the frame grid, are never written. Both memories sit outside the block and have a read latency of one cycle.

Top module: `tile_xor_blitter`

## Requirements
- R1: A blit command gives its size as one 16-bit value: width in tiles in bits 7:0, height in tiles in bits 15:8. Source tile (column c, row r) has index base + r*width + c, taken modulo the cache tile count. Pixel row p of that tile is at cache byte index*8 + p, with bit 7 as the leftmost pixel.
- R2: In sprite mode the destination pixel at output coordinates (X, Y) equals the source pixel at (X - dx, Y - dy), or 0 where that point falls outside the source. dx and dy each range from 0 to 7.
- R3: A sprite blit covers width tile columns, plus one more when dx is nonzero, and height tile rows, plus one more when dy is nonzero.
- R4: A sprite blit XORs each output byte into the frame buffer, so the same sprite blitted twice at the same place leaves the frame buffer unchanged.
- R5: In background mode (cmd_bg = 1) the bitmap is tiled xrep times across and yrep times down, and the bytes overwrite the frame buffer. dx and dy have no effect.
- R6: Only output tiles at column offset below the clip width and row offset below the clip height, both counted from the pen, are written. After reset the clip extent is 255 by 255.
- R7: Frame byte address = ((pen_row + tile row)*GRID_W + pen_col + tile column)*8 + pixel row. Writes at a tile column of GRID_W or more, or a tile row of GRID_H or more, are suppressed.
- R8: cmd_op 0 loads the pen from cmd_x and cmd_y, cmd_op 1 loads the clip extent from cmd_x and cmd_y, and cmd_op 2 starts a blit. The pen resets to (0, 0). After a blit, pen_col advances by the number of output tile columns, modulo 256, and pen_row is unchanged.
- R9: busy is high while a blit runs. done pulses for one cycle as busy falls. Every command presented while busy is ignored.
- R10: A blit with zero width or zero height, or a background blit with a zero repeat count, writes nothing, leaves the pen unchanged and still pulses done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 pen load, 1 clip load, 2 blit, 3 no-op |
| cmd_x | input | 8 | Pen column or clip width |
| cmd_y | input | 8 | Pen row or clip height |
| cmd_tile | input | TC_AW-3 | First cache tile of the bitmap |
| cmd_dim | input | 16 | height*256 + width, in tiles |
| cmd_dx | input | 3 | Right pixel shift |
| cmd_dy | input | 3 | Down pixel shift |
| cmd_bg | input | 1 | 1 selects background overwrite mode |
| cmd_xrep | input | REP_W | Horizontal repeat count (background) |
| cmd_yrep | input | REP_W | Vertical repeat count (background) |
| busy | output | 1 | Blit in progress |
| done | output | 1 | One-cycle completion pulse |
| pen_col | output | 8 | Pen tile column |
| pen_row | output | 8 | Pen tile row |
| tc_rd_en | output | 1 | Tile cache read strobe |
| tc_rd_addr | output | TC_AW | Tile cache byte address |
| tc_rd_data | input | 8 | Tile cache data, one cycle after the strobe |
| fb_rd_en | output | 1 | Frame buffer read strobe |
| fb_rd_addr | output | FB_AW | Frame buffer read address |
| fb_rd_data | input | 8 | Frame buffer data, one cycle after the strobe |
| fb_wr_en | output | 1 | Frame buffer write strobe |
| fb_wr_addr | output | FB_AW | Frame buffer write address |
| fb_wr_data | output | 8 | Frame buffer write data |

## Verification
The bench uses the default parameters: a 20 by 20 tile grid, a 64-tile cache (TC_AW = 9) and 4-bit repeat counts. The small grid lets a pen placed near the right or bottom edge drive blits past the grid limits, so write suppression at the edges is tested. The 64-tile cache lets random bases plus row offsets run past the end of the cache, so the modulo wrap of the tile index is tested. Random sprite and background blits with random shifts, pen positions and clip extents are checked against a pixel-by-pixel model of the whole frame buffer.

// File: rtl/tile_blit_pkg.sv
package tile_blit_pkg;

   typedef enum logic [1:0] {
      OP_PEN  = 2'd0,
      OP_CLIP = 2'd1,
      OP_BLIT = 2'd2,
      OP_NOP  = 2'd3
   } blit_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SRC_A,
      ST_SRC_B,
      ST_DST,
      ST_WRITE
   } blit_state_e;

   // geometry of the running blit, latched at acceptance
   typedef struct packed {
      logic [7:0] w;
      logic [7:0] h;
      logic [2:0] dx;
      logic [2:0] dy;
      logic       bg;
   } blit_geom_t;

   // right shift of the current source byte, with the left neighbour
   // feeding its low bits in from the top
   function automatic logic [7:0] merge_shift(input logic [7:0] cur,
                                              input logic [7:0] left,
                                              input logic [2:0] sh);
      logic [15:0] pair;
      pair = {left, cur} >> sh;
      return pair[7:0];
   endfunction

endpackage

// File: rtl/blit_pen_unit.sv
module blit_pen_unit #(
   parameter int         CNT_W    = 16,
   parameter logic [7:0] CLIP_RST = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_pen,
   input  logic             ld_clip,
   input  logic [7:0]       val_x,
   input  logic [7:0]       val_y,
   input  logic             adv,
   input  logic [CNT_W-1:0] adv_cols,
   output logic [7:0]       pen_col,
   output logic [7:0]       pen_row,
   output logic [7:0]       clip_w,
   output logic [7:0]       clip_h
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pen_col <= '0;
         pen_row <= '0;
         clip_w  <= CLIP_RST;
         clip_h  <= CLIP_RST;
      end else begin
         if (ld_pen) begin
            pen_col <= val_x;
            pen_row <= val_y;
         end else if (adv) begin
            pen_col <= pen_col + adv_cols[7:0];
         end
         if (ld_clip) begin
            clip_w <= val_x;
            clip_h <= val_y;
         end
      end
   end

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [CNT_W-1:0] ext_w,
   input  logic [CNT_W-1:0] ext_h_px,
   input  logic [CNT_W-1:0] wrap_w,
   input  logic [CNT_W-1:0] wrap_h_px,
   output logic [CNT_W-1:0] oc,
   output logic [CNT_W-1:0] py,
   output logic [CNT_W-1:0] wc,
   output logic [CNT_W-1:0] wy,
   output logic             last
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic col_end;
   assign col_end = (oc == ext_w - ONE);
   assign last    = col_end && (py == ext_h_px - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc <= '0;
         py <= '0;
         wc <= '0;
         wy <= '0;
      end else if (start) begin
         oc <= '0;
         py <= '0;
         wc <= '0;
         wy <= '0;
      end else if (step) begin
         if (col_end) begin
            oc <= '0;
            wc <= '0;
            py <= py + ONE;
            wy <= (wy == wrap_h_px - ONE) ? '0 : wy + ONE;
         end else begin
            oc <= oc + ONE;
            wc <= (wc == wrap_w - ONE) ? '0 : wc + ONE;
         end
      end
   end

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
   import tile_blit_pkg::*;
#(
   parameter int GRID_W = 20,
   parameter int GRID_H = 20,
   parameter int TC_AW  = 9,
   parameter int FB_AW  = 12,
   parameter int CNT_W  = 16
) (
   input  blit_geom_t            geom,
   input  logic [TC_AW-4:0]      base,
   input  logic [CNT_W-1:0]      oc,
   input  logic [CNT_W-1:0]      py,
   input  logic [CNT_W-1:0]      wc,
   input  logic [CNT_W-1:0]      wy,
   input  logic [7:0]            pen_col,
   input  logic [7:0]            pen_row,
   input  logic [7:0]            clip_w,
   input  logic [7:0]            clip_h,
   output logic [1:0][TC_AW-1:0] src_addr,
   output logic [1:0]            src_ok,
   output logic [FB_AW-1:0]      dst_addr,
   output logic                  dst_ok
);

   localparam int IW = TC_AW - 3;
   localparam int SW = CNT_W + 1;

   logic [SW-1:0] sy_raw, sy_sel;
   logic          row_ok;

   assign sy_raw = SW'(py) - SW'(geom.dy);
   assign sy_sel = geom.bg ? SW'(wy) : sy_raw;
   assign row_ok = geom.bg ||
                   ((py >= CNT_W'(geom.dy)) && (sy_raw < SW'({geom.h, 3'b000})));

   // lane 0 reads the column under the output byte, lane 1 its left neighbour
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [CNT_W-1:0] col;
      logic             col_ok;
      logic [IW-1:0]    idx;

      assign col    = geom.bg ? wc : (oc - CNT_W'(g));
      assign col_ok = geom.bg ? (g == 0)
                              : (((g == 0) || (oc != '0)) && (col < CNT_W'(geom.w)));
      assign idx    = IW'(sy_sel >> 3) * IW'(geom.w) + IW'(col) + base;
      assign src_addr[g] = {idx, sy_sel[2:0]};
      assign src_ok[g]   = row_ok && col_ok;
   end

   logic [SW-1:0] t_row, t_col;
   assign t_row = SW'(pen_row) + SW'(py >> 3);
   assign t_col = SW'(pen_col) + SW'(oc);

   assign dst_ok = (oc < CNT_W'(clip_w)) && ((py >> 3) < CNT_W'(clip_h)) &&
                   (t_col < SW'(GRID_W)) && (t_row < SW'(GRID_H));
   assign dst_addr = FB_AW'((FB_AW'(t_row) * FB_AW'(GRID_W) + FB_AW'(t_col)) * FB_AW'(8))
                     + FB_AW'(py[2:0]);

endmodule

// File: rtl/tile_xor_blitter.sv
module tile_xor_blitter
   import tile_blit_pkg::*;
#(
   parameter int GRID_W = 20,
   parameter int GRID_H = 20,
   parameter int TC_AW  = 9,
   parameter int FB_AW  = 12,
   parameter int REP_W  = 4,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [7:0]       cmd_x,
   input  logic [7:0]       cmd_y,
   input  logic [TC_AW-4:0] cmd_tile,
   input  logic [15:0]      cmd_dim,
   input  logic [2:0]       cmd_dx,
   input  logic [2:0]       cmd_dy,
   input  logic             cmd_bg,
   input  logic [REP_W-1:0] cmd_xrep,
   input  logic [REP_W-1:0] cmd_yrep,
   output logic             busy,
   output logic             done,
   output logic [7:0]       pen_col,
   output logic [7:0]       pen_row,
   output logic             tc_rd_en,
   output logic [TC_AW-1:0] tc_rd_addr,
   input  logic [7:0]       tc_rd_data,
   output logic             fb_rd_en,
   output logic [FB_AW-1:0] fb_rd_addr,
   input  logic [7:0]       fb_rd_data,
   output logic             fb_wr_en,
   output logic [FB_AW-1:0] fb_wr_addr,
   output logic [7:0]       fb_wr_data
);

   localparam int MAX_EXT_PX = (255 * ((1 << REP_W) - 1) + 1) * 8;

   if (GRID_W * GRID_H * 8 > (1 << FB_AW)) begin : g_bad_fb
      $error("FB_AW too narrow for the frame grid");
   end
   if (TC_AW < 4) begin : g_bad_tc
      $error("tile cache must hold at least two tiles");
   end
   if (MAX_EXT_PX >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for the largest blit extent");
   end

   blit_state_e      state_q;
   blit_geom_t       geom_q;
   logic [TC_AW-4:0] base_q;
   logic [CNT_W-1:0] ext_w_q, ext_h_px_q;
   logic [7:0]       a_byte_q, b_byte_q;
   logic             done_q;

   logic [7:0] clip_w, clip_h;
   logic [CNT_W-1:0] oc, py, wc, wy;
   logic             last;
   logic [1:0][TC_AW-1:0] src_addr;
   logic [1:0]            src_ok;
   logic [FB_AW-1:0]      dst_addr;
   logic                  dst_ok;

   // command decode
   logic       accept, go_blit, go_pen, go_clip, empty;
   logic [7:0] c_w, c_h;
   logic [CNT_W-1:0] n_w, n_h;

   assign c_w     = cmd_dim[7:0];
   assign c_h     = cmd_dim[15:8];
   assign accept  = cmd_valid && (state_q == ST_IDLE);
   assign go_blit = accept && (blit_op_e'(cmd_op) == OP_BLIT);
   assign go_pen  = accept && (blit_op_e'(cmd_op) == OP_PEN);
   assign go_clip = accept && (blit_op_e'(cmd_op) == OP_CLIP);
   assign empty   = (c_w == '0) || (c_h == '0) ||
                    (cmd_bg && ((cmd_xrep == '0) || (cmd_yrep == '0)));

   always_comb begin
      if (cmd_bg) begin
         n_w = CNT_W'(c_w) * CNT_W'(cmd_xrep);
         n_h = CNT_W'(c_h) * CNT_W'(cmd_yrep);
      end else begin
         n_w = CNT_W'(c_w) + CNT_W'(cmd_dx != 3'd0);
         n_h = CNT_W'(c_h) + CNT_W'(cmd_dy != 3'd0);
      end
   end

   // sequencer: four cycles per destination byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         geom_q     <= '0;
         base_q     <= '0;
         ext_w_q    <= '0;
         ext_h_px_q <= '0;
         a_byte_q   <= '0;
         b_byte_q   <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (go_blit) begin
                  geom_q.w   <= c_w;
                  geom_q.h   <= c_h;
                  geom_q.dx  <= cmd_bg ? 3'd0 : cmd_dx;
                  geom_q.dy  <= cmd_bg ? 3'd0 : cmd_dy;
                  geom_q.bg  <= cmd_bg;
                  base_q     <= cmd_tile;
                  ext_w_q    <= empty ? '0 : n_w;
                  ext_h_px_q <= n_h << 3;
                  if (empty) done_q  <= 1'b1;
                  else       state_q <= ST_SRC_A;
               end
            end
            ST_SRC_A: state_q <= ST_SRC_B;
            ST_SRC_B: begin
               a_byte_q <= src_ok[0] ? tc_rd_data : 8'h00;
               state_q  <= ST_DST;
            end
            ST_DST: begin
               b_byte_q <= src_ok[1] ? tc_rd_data : 8'h00;
               state_q  <= ST_WRITE;
            end
            ST_WRITE: begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= ST_SRC_A;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   blit_pen_unit #(.CNT_W(CNT_W), .CLIP_RST(8'hFF)) u_pen (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_pen   (go_pen),
      .ld_clip  (go_clip),
      .val_x    (cmd_x),
      .val_y    (cmd_y),
      .adv      ((state_q == ST_WRITE) && last),
      .adv_cols (ext_w_q),
      .pen_col  (pen_col),
      .pen_row  (pen_row),
      .clip_w   (clip_w),
      .clip_h   (clip_h)
   );

   blit_walker #(.CNT_W(CNT_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go_blit && !empty),
      .step      (state_q == ST_WRITE),
      .ext_w     (ext_w_q),
      .ext_h_px  (ext_h_px_q),
      .wrap_w    (CNT_W'(geom_q.w)),
      .wrap_h_px (CNT_W'({geom_q.h, 3'b000})),
      .oc        (oc),
      .py        (py),
      .wc        (wc),
      .wy        (wy),
      .last      (last)
   );

   blit_addr_gen #(
      .GRID_W (GRID_W),
      .GRID_H (GRID_H),
      .TC_AW  (TC_AW),
      .FB_AW  (FB_AW),
      .CNT_W  (CNT_W)
   ) u_addr (
      .geom     (geom_q),
      .base     (base_q),
      .oc       (oc),
      .py       (py),
      .wc       (wc),
      .wy       (wy),
      .pen_col  (pen_col),
      .pen_row  (pen_row),
      .clip_w   (clip_w),
      .clip_h   (clip_h),
      .src_addr (src_addr),
      .src_ok   (src_ok),
      .dst_addr (dst_addr),
      .dst_ok   (dst_ok)
   );

   logic [7:0] shaped;
   assign shaped = geom_q.bg ? a_byte_q : merge_shift(a_byte_q, b_byte_q, geom_q.dx);

   assign tc_rd_en   = ((state_q == ST_SRC_A) && src_ok[0]) ||
                       ((state_q == ST_SRC_B) && src_ok[1]);
   assign tc_rd_addr = (state_q == ST_SRC_B) ? src_addr[1] : src_addr[0];
   assign fb_rd_en   = (state_q == ST_DST) && dst_ok;
   assign fb_rd_addr = dst_addr;
   assign fb_wr_en   = (state_q == ST_WRITE) && dst_ok;
   assign fb_wr_addr = dst_addr;
   assign fb_wr_data = geom_q.bg ? shaped : (fb_rd_data ^ shaped);

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

endmodule

// File: rtl/tile_xor_blitter_chk.sv
module tile_xor_blitter_chk #(
   parameter int GRID_W = 20,
   parameter int GRID_H = 20,
   parameter int FB_AW  = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic [7:0]       pen_col,
   input logic [7:0]       pen_row,
   input logic             fb_rd_en,
   input logic [FB_AW-1:0] fb_rd_addr,
   input logic             fb_wr_en,
   input logic [FB_AW-1:0] fb_wr_addr
);

   localparam logic [FB_AW:0] FB_BYTES = (FB_AW+1)'(GRID_W * GRID_H * 8);

   p_wr_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fb_wr_en |-> busy);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_wr_in_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fb_wr_en |-> ({1'b0, fb_wr_addr} < FB_BYTES));

   p_rmw_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fb_wr_en |-> ($past(fb_rd_en) && ($past(fb_rd_addr) == fb_wr_addr)));

   p_pen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(pen_col) && $stable(pen_row)));

endmodule

bind tile_xor_blitter tile_xor_blitter_chk #(
   .GRID_W (GRID_W),
   .GRID_H (GRID_H),
   .FB_AW  (FB_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .pen_col    (pen_col),
   .pen_row    (pen_row),
   .fb_rd_en   (fb_rd_en),
   .fb_rd_addr (fb_rd_addr),
   .fb_wr_en   (fb_wr_en),
   .fb_wr_addr (fb_wr_addr)
);

// File: tb/tb_tile_xor_blitter.sv
module tb_tile_xor_blitter;

   localparam int GW = 20;
   localparam int GH = 20;
   localparam int TC_AW = 9;
   localparam int FB_AW = 12;
   localparam int REP_W = 4;
   localparam int NT = 1 << (TC_AW - 3);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             cmd_valid = 1'b0;
   logic [1:0]       cmd_op = 2'd3;
   logic [7:0]       cmd_x = '0, cmd_y = '0;
   logic [TC_AW-4:0] cmd_tile = '0;
   logic [15:0]      cmd_dim = '0;
   logic [2:0]       cmd_dx = '0, cmd_dy = '0;
   logic             cmd_bg = 1'b0;
   logic [REP_W-1:0] cmd_xrep = '0, cmd_yrep = '0;
   logic             busy, done;
   logic [7:0]       pen_col, pen_row;
   logic             tc_rd_en, fb_rd_en, fb_wr_en;
   logic [TC_AW-1:0] tc_rd_addr;
   logic [FB_AW-1:0] fb_rd_addr, fb_wr_addr;
   logic [7:0]       tc_rd_data = '0, fb_rd_data = '0, fb_wr_data;

   tile_xor_blitter #(.GRID_W(GW), .GRID_H(GH), .TC_AW(TC_AW), .FB_AW(FB_AW),
                      .REP_W(REP_W), .CNT_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_tile(cmd_tile), .cmd_dim(cmd_dim),
      .cmd_dx(cmd_dx), .cmd_dy(cmd_dy), .cmd_bg(cmd_bg), .cmd_xrep(cmd_xrep),
      .cmd_yrep(cmd_yrep), .busy(busy), .done(done), .pen_col(pen_col),
      .pen_row(pen_row), .tc_rd_en(tc_rd_en), .tc_rd_addr(tc_rd_addr),
      .tc_rd_data(tc_rd_data), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
      .fb_rd_data(fb_rd_data), .fb_wr_en(fb_wr_en), .fb_wr_addr(fb_wr_addr),
      .fb_wr_data(fb_wr_data)
   );

   logic [7:0] tmem [1 << TC_AW];
   logic [7:0] fbm  [1 << FB_AW];
   logic [7:0] efb  [1 << FB_AW];
   logic [7:0] snap [1 << FB_AW];

   always @(posedge clk) begin
      if (tc_rd_en) tc_rd_data <= tmem[tc_rd_addr];
      if (fb_rd_en) fb_rd_data <= fbm[fb_rd_addr];
      if (fb_wr_en) fbm[fb_wr_addr] <= fb_wr_data;
   end

   int total = 0, bad = 0, cyc = 0;
   int m_pc = 0, m_pr = 0, m_cw = 255, m_ch = 255;
   bit finished = 0;

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete act=%0d exp=%0d", cyc, 190000);
         summary();
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic cmp_fb(string req);
      int miss = 0, first = -1;
      for (int i = 0; i < GW * GH * 8; i++)
         if (fbm[i] !== efb[i]) begin
            miss++;
            if (first < 0) first = i;
         end
      total++;
      if (miss != 0) begin
         bad++;
         $display("FAIL %s frame byte %0d act=%0d exp=%0d (%0d bytes differ)",
                  req, first, fbm[first], efb[first], miss);
      end
   endtask

   function automatic bit src_bit(int base, int w, int sx, int sy);
      int t;
      logic [7:0] b;
      t = (base + (sy / 8) * w + sx / 8) % NT;
      b = tmem[t * 8 + sy % 8];
      return b[7 - sx % 8];
   endfunction

   // pixel-level reference for one blit, using the modelled pen and clip
   task automatic model_blit(int base, int w, int h, int dx, int dy, bit bg, int xr, int yr);
      int ow, oh;
      if (w == 0 || h == 0 || (bg && (xr == 0 || yr == 0))) return;
      ow = bg ? w * xr : w + (dx != 0 ? 1 : 0);
      oh = bg ? h * yr : h + (dy != 0 ? 1 : 0);
      for (int ty = 0; ty < oh; ty++)
         for (int p = 0; p < 8; p++)
            for (int tx = 0; tx < ow; tx++) begin
               logic [7:0] v = '0;
               for (int k = 0; k < 8; k++) begin
                  int px = tx * 8 + k, py = ty * 8 + p;
                  if (bg) v[7-k] = src_bit(base, w, px % (8 * w), py % (8 * h));
                  else if (px - dx >= 0 && px - dx < 8 * w && py - dy >= 0 && py - dy < 8 * h)
                     v[7-k] = src_bit(base, w, px - dx, py - dy);
               end
               if (tx < m_cw && ty < m_ch && m_pc + tx < GW && m_pr + ty < GH) begin
                  int a = ((m_pr + ty) * GW + m_pc + tx) * 8 + p;
                  efb[a] = bg ? v : (efb[a] ^ v);
               end
            end
      m_pc = (m_pc + ow) % 256;
   endtask

   task automatic send(int op, int x, int y);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_x = 8'(x); cmd_y = 8'(y);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd3;
      if (op == 0) begin m_pc = x; m_pr = y; end
      if (op == 1) begin m_cw = x; m_ch = y; end
   endtask

   task automatic blit(int base, int w, int h, int dx, int dy, bit bg, int xr, int yr,
                       bit poke, string req);
      model_blit(base, w, h, dx, dy, bg, xr, yr);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_tile = (TC_AW-3)'(base);
      cmd_dim = 16'(h * 256 + w); cmd_dx = 3'(dx); cmd_dy = 3'(dy); cmd_bg = bg;
      cmd_xrep = REP_W'(xr); cmd_yrep = REP_W'(yr);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd3;
      if (poke && busy) begin
         // pen load and a second blit presented while busy must be dropped
         cmd_valid = 1'b1; cmd_op = 2'd0; cmd_x = 8'd9; cmd_y = 8'd9;
         @(negedge clk);
         cmd_op = 2'd2;
         @(negedge clk);
         cmd_valid = 1'b0; cmd_op = 2'd3;
      end
      while (!done) @(negedge clk);
      chk(!busy, {req, " busy low with done"}, busy, 0);
      cmp_fb(req);
      chk(pen_col == 8'(m_pc) && pen_row == 8'(m_pr), {req, " R8 pen after blit"},
          pen_col * 256 + pen_row, m_pc * 256 + m_pr);
      @(negedge clk);
      chk(!done, {req, " R9 done one cycle"}, done, 0);
   endtask

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < (1 << TC_AW); i++) tmem[i] = 8'($urandom);
      for (int i = 0; i < (1 << FB_AW); i++) begin
         fbm[i] = 8'($urandom);
         efb[i] = fbm[i];
      end
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R9 reset idle", busy * 2 + done, 0);
      chk(pen_col == 0 && pen_row == 0, "R8 reset pen", pen_col * 256 + pen_row, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4: plain sprite, then again to erase it
      for (int i = 0; i < (1 << FB_AW); i++) snap[i] = fbm[i];
      send(0, 2, 3);
      blit(5, 1, 1, 0, 0, 0, 0, 0, 0, "R1 unshifted sprite");
      send(0, 2, 3);
      blit(5, 1, 1, 0, 0, 0, 0, 0, 0, "R4 second xor");
      begin
         int diff = 0;
         for (int i = 0; i < GW * GH * 8; i++) if (fbm[i] !== snap[i]) diff++;
         chk(diff == 0, "R4 double blit restores frame", diff, 0);
      end

      // R2 R3: shifted 2x2 sprite spills into a third column and row
      send(0, 4, 6);
      blit(10, 2, 2, 3, 5, 0, 0, 0, 0, "R2 R3 shifted sprite");
      chk(pen_col == 8'd7, "R3 pen moved by w+1", pen_col, 7);

      // R5: background repeat, shift ignored
      send(0, 0, 10);
      blit(20, 2, 1, 5, 2, 1, 3, 2, 0, "R5 background repeat");

      // R6: clip to one tile
      send(0, 10, 0);
      send(1, 1, 1);
      blit(30, 3, 3, 2, 1, 0, 0, 0, 0, "R6 clip one tile");
      send(1, 255, 255);

      // R7: pen near corner, writes past the grid suppressed
      send(0, 18, 19);
      blit(40, 4, 2, 1, 0, 0, 0, 0, 0, "R7 grid edge");
      chk(pen_col == 8'd23, "R7 pen past grid", pen_col, 23);

      // R9: commands while busy ignored
      send(0, 0, 0);
      blit(3, 2, 2, 0, 4, 0, 0, 0, 1, "R9 busy ignores commands");

      // R10: empty extents
      blit(7, 0, 2, 1, 1, 0, 0, 0, 0, "R10 zero width");
      blit(7, 2, 2, 0, 0, 1, 0, 2, 0, "R10 zero repeat");

      // random mix
      for (int n = 0; n < 30; n++) begin
         int bg;
         if ($urandom_range(0, 2) == 0) send(0, $urandom_range(0, 21), $urandom_range(0, 21));
         if ($urandom_range(0, 4) == 0) send(1, $urandom_range(0, 4), $urandom_range(0, 4));
         else if ($urandom_range(0, 3) == 0) send(1, 255, 255);
         bg = $urandom_range(0, 2) == 0 ? 1 : 0;
         blit($urandom_range(0, NT - 1), $urandom_range(0, 3), $urandom_range(0, 3),
              $urandom_range(0, 7), $urandom_range(0, 7), bit'(bg),
              $urandom_range(0, 2), $urandom_range(0, 2), bit'($urandom_range(0, 5) == 0),
              bg ? "R5 random background" : "R2 random sprite");
      end
      summary();
   end

endmodule